// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a data cache that sits between a processor and a block-oriented memory. The processor issues one-word reads and writes on a 32-bit byte address. The cache keeps a parameterised number of lines. Each line holds a valid bit, a dirty bit, a tag and one 128-bit block of four words. A given memory block can live in only one line: the block number modulo the number of lines selects it. The cache answers hits in the same cycle. On a miss it raises a stall and fetches the whole block over a request/acknowledge memory port.

A parameter picks the write policy. In write-back mode, writes touch only the cache and mark the line dirty. A dirty line goes back to memory as a full block, and only when it is replaced. In write-through mode, every write is also queued as a single-word memory write in a four-entry first-in first-out buffer. A write stalls only when that buffer is full. Write misses do not allocate, and a read miss refills only after the buffer has emptied.

The processor holds its request (address, direction, data) unchanged while the stall output is high. A request completes at the clock edge where the request is high and the stall is low.

Top module: `dmc_cache`

## Requirements
- R1: The address is split from the least significant bit upward: bits [1:0] select a byte and are ignored, bits [3:2] select the word within the block, the next log2(LINES) bits select the line, and the remaining upper bits form the tag.
- R2: Reset clears every valid and dirty bit, so the first access to any address after reset is a miss and causes no write of an old line.
- R3: A hit needs the selected line to be valid with a stored tag equal to the address tag. A read hit returns the word with the stall low in the same cycle and makes no memory request.
- R4: A miss holds the stall high and issues a block read (mem_we=0, mem_word=0) at the address with bits [3:0] cleared. Word k of the block travels on mem_rdata bits [32k+31:32k]. The stall drops once the requested word is in the line.
- R5: In write-back mode, a write hit updates only the cached word and sets the line's dirty bit, with no memory request and no stall.
- R6: In write-back mode, a miss on a dirty line first writes the old block (mem_we=1, mem_word=0) to the address built from its stored tag and index, and the refill read is issued only after that write is acknowledged. A clean line is replaced without a write.
- R7: In write-back mode, a write miss fetches the block, then merges the word, leaving the line dirty.
- R8: In write-through mode, every write is sent to memory as a single-word write (mem_we=1, mem_word=1, word address on mem_addr, data on mem_wdata[31:0]). A write hit also updates the cache. A write miss leaves the cache unchanged, so a later read of that address misses.
- R9: In write-through mode, the write buffer holds four writes and sends them to memory in the order they were accepted. A write stalls only while the buffer is full.
- R10: In write-through mode, a read miss waits until the write buffer is empty before it refills, so it sees earlier writes to the same block. No block write to memory ever occurs.
- R11: Once mem_req is raised, it stays high with mem_addr, mem_we and mem_word unchanged until mem_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address of the access |
| cpu_wdata | input | 32 | Write data word |
| cpu_rdata | output | 32 | Read data word, valid when the stall is low |
| cpu_stall | output | 1 | Request cannot complete this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = memory write, 0 = block read |
| mem_word | output | 1 | 1 = single-word write, 0 = whole-block transfer |
| mem_addr | output | 32 | Block address, or word address for single-word writes |
| mem_wdata | output | 128 | Block write data; word writes use bits [31:0] |
| mem_ack | input | 1 | Transfer done; one-cycle pulse |
| mem_rdata | input | 128 | Block read data, valid with mem_ack |

## Verification
Write-back mode is driven through a sequence that tells apart:
- repeated hits on one block, including an address that differs only in the ignored byte bits;
- two tags competing for one line, first with a dirty victim and then with a clean one, so that the block-write count shows whether the dirty bit was honoured;
- a write miss followed by reads of both the merged word and its neighbour, which separates allocation from plain forwarding.

A dirty line abandoned by reset tells a cleared dirty bit from a stale one.

In write-through mode, the bench covers:
- a write hit and a write miss, where the read that follows tells allocation from non-allocation;
- a burst of five writes against a slow memory, which tells a buffer that stalls at four from one that never fills, and whose memory log shows the draining order;
- a read issued right behind a write to the same block, which shows whether the read waited for the buffer to drain.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int ADDR_W    = 32;
    localparam int WORD_W    = 32;
    localparam int BLK_WORDS = 4;
    localparam int BLK_W     = WORD_W * BLK_WORDS;
    localparam int OFS_W     = 4;   // byte (2) + word-in-block (2)

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VICTIM,
        ST_REFILL
    } dmc_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] data;
    } wbuf_entry_t;

    function automatic logic [ADDR_W-1:0] block_base(input logic [ADDR_W-1:0] a);
        return {a[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
    endfunction

    function automatic logic [WORD_W-1:0] pick_word(input logic [BLK_W-1:0] blk,
                                                    input logic [1:0] w);
        return blk[w*WORD_W +: WORD_W];
    endfunction

    function automatic logic [BLK_W-1:0] merge_word(input logic [BLK_W-1:0] blk,
                                                    input logic [1:0] w,
                                                    input logic [WORD_W-1:0] d);
        logic [BLK_W-1:0] r;
        r = blk;
        r[w*WORD_W +: WORD_W] = d;
        return r;
    endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic             rd_dirty,
    output logic [TAG_W-1:0] rd_tag,
    output logic [BLK_W-1:0] rd_data,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_dirty,
    input  logic [BLK_W-1:0] wr_data
);

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [BLK_W-1:0] data_q [LINES];

    // Status bits carry reset; tag and data do not need it.
    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            dirty_q[wr_idx] <= wr_dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_tag;
            data_q[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

endmodule

// File: rtl/dmc_wbuf.sv
module dmc_wbuf
    import dmc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  wbuf_entry_t push_ent,
    input  logic        pop,
    output wbuf_entry_t head,
    output logic        empty,
    output logic        full
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = PTR_W + 1;

    wbuf_entry_t      ent_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
            if (pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) ent_q[wr_ptr_q] <= push_ent;
    end

    assign head  = ent_q[rd_ptr_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/dmc_cache.sv
module dmc_cache
    import dmc_pkg::*;
#(
    parameter int LINES      = 16,
    parameter bit WRITE_BACK = 1'b1,
    parameter int WBUF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_stall,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_word,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [BLK_W-1:0]  mem_rdata
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W - OFS_W;

    dmc_state_e       state_q, state_d;
    logic [IDX_W-1:0] idx;
    logic [TAG_W-1:0] tag;
    logic [1:0]       wsel;
    logic             rd_valid, rd_dirty, hit, accept, refill_done;
    logic [TAG_W-1:0] rd_tag;
    logic [BLK_W-1:0] rd_data;
    logic             wr_en, wr_dirty;
    logic [BLK_W-1:0] wr_data;
    logic             wb_empty, wb_full;
    wbuf_entry_t      wb_head;

    wire unused_byte_bits = ^cpu_addr[1:0];

    assign wsel = cpu_addr[3:2];
    assign idx  = cpu_addr[OFS_W +: IDX_W];
    assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];

    dmc_line_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_lines (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (idx),
        .rd_valid (rd_valid),
        .rd_dirty (rd_dirty),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_tag   (tag),
        .wr_dirty (wr_dirty),
        .wr_data  (wr_data)
    );

    assign hit       = rd_valid && (rd_tag == tag);
    assign cpu_rdata = pick_word(rd_data, wsel);

    always_comb begin
        if (state_q != ST_IDLE)
            cpu_stall = cpu_req;
        else if (WRITE_BACK)
            cpu_stall = cpu_req && !hit;
        else
            cpu_stall = cpu_req && (cpu_we ? wb_full : !hit);
    end

    assign accept      = cpu_req && !cpu_stall;
    assign refill_done = (state_q == ST_REFILL) && mem_ack;
    assign wr_en       = refill_done || (accept && cpu_we && hit);
    assign wr_data     = refill_done ? mem_rdata : merge_word(rd_data, wsel, cpu_wdata);
    assign wr_dirty    = !refill_done && WRITE_BACK;

    // Write buffer only exists for the write-through variant.
    generate
        if (!WRITE_BACK) begin : g_wt
            logic        wb_push, wb_pop;
            wbuf_entry_t wb_ent;
            assign wb_push     = accept && cpu_we;
            assign wb_pop      = (state_q == ST_IDLE) && mem_ack;
            assign wb_ent.addr = {cpu_addr[ADDR_W-1:2], 2'b00};
            assign wb_ent.data = cpu_wdata;
            dmc_wbuf #(.DEPTH(WBUF_DEPTH)) i_wbuf (
                .clk      (clk),
                .rst      (rst),
                .push     (wb_push),
                .push_ent (wb_ent),
                .pop      (wb_pop),
                .head     (wb_head),
                .empty    (wb_empty),
                .full     (wb_full)
            );
        end else begin : g_wb
            assign wb_empty = 1'b1;
            assign wb_full  = 1'b0;
            assign wb_head  = '0;
        end
    endgenerate

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req && !hit) begin
                    if (WRITE_BACK)
                        state_d = (rd_valid && rd_dirty) ? ST_VICTIM : ST_REFILL;
                    else if (!cpu_we && wb_empty)
                        state_d = ST_REFILL;
                end
            end
            ST_VICTIM: if (mem_ack) state_d = ST_REFILL;
            ST_REFILL: if (mem_ack) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        case (state_q)
            ST_VICTIM: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_word  = 1'b0;
                mem_addr  = {rd_tag, idx, {OFS_W{1'b0}}};
                mem_wdata = rd_data;
            end
            ST_REFILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b0;
                mem_word  = 1'b0;
                mem_addr  = block_base(cpu_addr);
                mem_wdata = '0;
            end
            default: begin
                mem_req   = !wb_empty;
                mem_we    = 1'b1;
                mem_word  = 1'b1;
                mem_addr  = wb_head.addr;
                mem_wdata = {{(BLK_W-WORD_W){1'b0}}, wb_head.data};
            end
        endcase
    end

endmodule

// File: rtl/dmc_cache_chk.sv
module dmc_cache_chk #(
    parameter bit WRITE_BACK = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_stall,
    input logic        mem_req,
    input logic        mem_we,
    input logic        mem_word,
    input logic        mem_ack,
    input logic [31:0] mem_addr,
    input logic        wb_empty
);

    // R4: while a block transfer is in flight the processor is held
    a_r4_stall_on_block_xfer: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && mem_req && !mem_word) |-> cpu_stall);

    // R6: acknowledged victim write is followed at once by the refill read
    a_r6_refill_after_victim: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_ack && mem_we && !mem_word) |=> (mem_req && !mem_we));

    // R5: write-back never emits single-word writes
    a_r5_wb_no_word_write: assert property (@(posedge clk) disable iff (rst)
        (WRITE_BACK && mem_req) |-> !mem_word);

    // R8: write-through memory writes are always single words
    a_r8_wt_word_writes: assert property (@(posedge clk) disable iff (rst)
        (!WRITE_BACK && mem_req && mem_we) |-> mem_word);

    // R10: a refill read only runs with an empty write buffer
    a_r10_refill_after_drain: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> wb_empty);

    // R11: request and its command are held until acknowledged
    a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_word)));

endmodule

bind dmc_cache dmc_cache_chk #(.WRITE_BACK(WRITE_BACK)) i_dmc_cache_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_stall (cpu_stall),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_word  (mem_word),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr),
    .wb_empty  (wb_empty)
);

// File: tb/test_dmc_cache.sv
`timescale 1ns/1ps

module tb_mem_model #(
    parameter int LAT = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         req,
    input  logic         we,
    input  logic         word,
    input  logic [31:0]  addr,
    input  logic [127:0] wdata,
    output logic         ack,
    output logic [127:0] rdata
);
    logic [127:0] mem [256];
    int cnt;
    int n_rd, n_bw, n_ww, viol, n_log;
    logic [31:0] last_bw_addr, last_rd_addr;
    logic [31:0] log_q [16];
    logic        pend_q;
    logic [31:0] pend_addr_q;
    logic        pend_we_q, pend_word_q;

    initial begin
        for (int b = 0; b < 256; b++)
            for (int k = 0; k < 4; k++)
                mem[b][k*32 +: 32] = 32'h5A00_0000 ^ {20'h0, b[7:0], k[1:0], 2'b00};
        n_rd = 0; n_bw = 0; n_ww = 0; viol = 0; n_log = 0;
        last_bw_addr = '0; last_rd_addr = '0;
    end

    assign rdata = mem[addr[11:4]];

    always @(posedge clk) begin
        if (rst) begin
            ack <= 1'b0;
            cnt <= 0;
            pend_q <= 1'b0;
        end else begin
            if (pend_q && (!req || addr != pend_addr_q || we != pend_we_q || word != pend_word_q))
                viol <= viol + 1;
            pend_q      <= req && !ack;
            pend_addr_q <= addr;
            pend_we_q   <= we;
            pend_word_q <= word;
            if (ack) begin
                ack <= 1'b0;
                cnt <= 0;
                if (req && we && word) begin
                    mem[addr[11:4]][addr[3:2]*32 +: 32] <= wdata[31:0];
                    n_ww <= n_ww + 1;
                    if (n_log < 16) log_q[n_log] <= addr;
                    n_log <= n_log + 1;
                end else if (req && we) begin
                    mem[addr[11:4]] <= wdata;
                    n_bw <= n_bw + 1;
                    last_bw_addr <= addr;
                end else if (req) begin
                    n_rd <= n_rd + 1;
                    last_rd_addr <= addr;
                end
            end else if (req) begin
                if (cnt == LAT - 1) ack <= 1'b1;
                else cnt <= cnt + 1;
            end
        end
    end
endmodule

module test_dmc_cache;

    logic clk = 1'b0;
    logic rst;
    always #5 clk = ~clk;

    // side 0: write-back, side 1: write-through
    logic        req0, we0, req1, we1;
    logic [31:0] addr0, wd0, addr1, wd1;
    logic [31:0] rd0, rd1;
    logic        stall0, stall1;
    logic        mreq0, mwe0, mword0, mack0, mreq1, mwe1, mword1, mack1;
    logic [31:0] maddr0, maddr1;
    logic [127:0] mwd0, mrd0, mwd1, mrd1;

    dmc_cache #(.LINES(16), .WRITE_BACK(1'b1), .WBUF_DEPTH(4)) i_dmc_cache (
        .clk(clk), .rst(rst), .cpu_req(req0), .cpu_we(we0), .cpu_addr(addr0),
        .cpu_wdata(wd0), .cpu_rdata(rd0), .cpu_stall(stall0), .mem_req(mreq0),
        .mem_we(mwe0), .mem_word(mword0), .mem_addr(maddr0), .mem_wdata(mwd0),
        .mem_ack(mack0), .mem_rdata(mrd0));

    dmc_cache #(.LINES(16), .WRITE_BACK(1'b0), .WBUF_DEPTH(4)) i_dmc_cache_wt (
        .clk(clk), .rst(rst), .cpu_req(req1), .cpu_we(we1), .cpu_addr(addr1),
        .cpu_wdata(wd1), .cpu_rdata(rd1), .cpu_stall(stall1), .mem_req(mreq1),
        .mem_we(mwe1), .mem_word(mword1), .mem_addr(maddr1), .mem_wdata(mwd1),
        .mem_ack(mack1), .mem_rdata(mrd1));

    tb_mem_model #(.LAT(4)) m0 (.clk(clk), .rst(rst), .req(mreq0), .we(mwe0), .word(mword0),
        .addr(maddr0), .wdata(mwd0), .ack(mack0), .rdata(mrd0));
    tb_mem_model #(.LAT(4)) m1 (.clk(clk), .rst(rst), .req(mreq1), .we(mwe1), .word(mword1),
        .addr(maddr1), .wdata(mwd1), .ack(mack1), .rdata(mrd1));

    int checks = 0;
    int errors = 0;

    function automatic logic [31:0] pat(input logic [31:0] a);
        return 32'h5A00_0000 ^ {a[31:2], 2'b00};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input bit s, input bit we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] q, output int stalls);
        @(negedge clk);
        if (s) begin req1 = 1'b1; we1 = we; addr1 = a; wd1 = d; end
        else   begin req0 = 1'b1; we0 = we; addr0 = a; wd0 = d; end
        stalls = 0;
        forever begin
            #1;
            if (!(s ? stall1 : stall0)) break;
            stalls++;
            @(negedge clk);
        end
        q = s ? rd1 : rd0;
        @(posedge clk);
        #1;
        if (s) req1 = 1'b0; else req0 = 1'b0;
    endtask

    // {we, addr, wdata, expected read, refills, block writes}
    localparam int NV = 12;
    localparam logic [100:0] VEC [NV] = '{
        {1'b0, 32'h0000_0104, 32'h0,         32'h5A00_0104, 2'd1, 2'd0}, // R2 R4 cold miss
        {1'b0, 32'h0000_0108, 32'h0,         32'h5A00_0108, 2'd0, 2'd0}, // R3 hit
        {1'b0, 32'h0000_0109, 32'h0,         32'h5A00_0108, 2'd0, 2'd0}, // R1 byte bits ignored
        {1'b1, 32'h0000_0104, 32'h1111_1111, 32'h0,         2'd0, 2'd0}, // R5 write hit
        {1'b0, 32'h0000_0104, 32'h0,         32'h1111_1111, 2'd0, 2'd0}, // R5 read back
        {1'b0, 32'h0000_0204, 32'h0,         32'h5A00_0204, 2'd1, 2'd1}, // R6 dirty victim
        {1'b0, 32'h0000_0104, 32'h0,         32'h1111_1111, 2'd1, 2'd0}, // R6 clean victim, data kept
        {1'b1, 32'h0000_0318, 32'h2222_2222, 32'h0,         2'd1, 2'd0}, // R7 write allocate
        {1'b0, 32'h0000_0314, 32'h0,         32'h5A00_0314, 2'd0, 2'd0}, // R7 neighbour word
        {1'b0, 32'h0000_0318, 32'h0,         32'h2222_2222, 2'd0, 2'd0}, // R7 merged word
        {1'b0, 32'h0000_0118, 32'h0,         32'h5A00_0118, 2'd1, 2'd1}, // R6 evict allocated line
        {1'b0, 32'h0000_031C, 32'h0,         32'h5A00_031C, 2'd1, 2'd0}  // R1 tag compare
    };

    initial begin
        logic [31:0] q;
        int st, rd_b, bw_b, ww_b;
        rst = 1'b1;
        req0 = 0; we0 = 0; addr0 = 0; wd0 = 0;
        req1 = 0; we1 = 0; addr1 = 0; wd1 = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R2 reset stall", {31'b0, stall0}, 32'd0);
        chk("R2 reset mem_req", {31'b0, mreq0 | mreq1}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        // write-back vector walk
        for (int i = 0; i < NV; i++) begin
            logic [100:0] v;
            v = VEC[i];
            rd_b = m0.n_rd; bw_b = m0.n_bw;
            access(1'b0, v[100], v[99:68], v[67:36], q, st);
            if (!v[100]) chk($sformatf("R3/R4 vec%0d rdata", i), q, v[35:4]);
            chk($sformatf("R4 vec%0d refills", i), m0.n_rd - rd_b, {30'b0, v[3:2]});
            chk($sformatf("R6 vec%0d block writes", i), m0.n_bw - bw_b, {30'b0, v[1:0]});
            if (v[3:0] == 4'd0) chk($sformatf("R3 vec%0d no stall", i), st, 0);
            else chk($sformatf("R4 vec%0d stalled", i), {31'b0, st > 0}, 32'd1);
        end
        chk("R6 victim address", m0.last_bw_addr, 32'h0000_0310);
        chk("R4 refill block-aligned", m0.last_rd_addr, 32'h0000_0310);
        chk("R5 no word writes in write-back", m0.n_ww, 0);

        // R2: dirty line dropped by reset is neither written nor hit
        access(1'b0, 1'b1, 32'h0000_031C, 32'h3333_3333, q, st);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd_b = m0.n_rd; bw_b = m0.n_bw;
        access(1'b0, 1'b0, 32'h0000_031C, 32'h0, q, st);
        chk("R2 miss after reset", m0.n_rd - rd_b, 1);
        chk("R2 no victim after reset", m0.n_bw - bw_b, 0);
        chk("R2 reset data from memory", q, pat(32'h31C));

        // write-through directed tests
        rd_b = m1.n_rd;
        access(1'b1, 1'b0, 32'h0000_0104, 32'h0, q, st);
        chk("R2 wt cold miss", m1.n_rd - rd_b, 1);
        chk("R4 wt refill data", q, pat(32'h104));
        access(1'b1, 1'b1, 32'h0000_0104, 32'hAAAA_0001, q, st);
        chk("R9 wt write no stall", st, 0);
        access(1'b1, 1'b0, 32'h0000_0104, 32'h0, q, st);
        chk("R8 wt hit updated", q, 32'hAAAA_0001);
        chk("R8 wt hit no stall", st, 0);
        rd_b = m1.n_rd;
        access(1'b1, 1'b1, 32'h0000_0208, 32'hBBBB_0002, q, st);
        chk("R8 wt write miss no refill", m1.n_rd - rd_b, 0);
        while (m1.n_ww < 2) @(posedge clk);
        chk("R8 wt word write address", m1.log_q[0], 32'h0000_0104);
        access(1'b1, 1'b0, 32'h0000_0208, 32'h0, q, st);
        chk("R8 wt no allocate, read misses", m1.n_rd - rd_b, 1);
        chk("R8 wt memory holds write", q, 32'hBBBB_0002);

        // R9: five back-to-back writes, fifth hits a full buffer
        ww_b = m1.n_ww;
        for (int i = 0; i < 5; i++) begin
            access(1'b1, 1'b1, 32'h0000_0400 + 32'(4*i), 32'hD000_0000 + 32'(i), q, st);
            if (i < 4) chk($sformatf("R9 write %0d no stall", i), st, 0);
            else chk("R9 stall when full", {31'b0, st > 0}, 32'd1);
        end
        while (m1.n_ww < ww_b + 5) @(posedge clk);
        for (int i = 0; i < 5; i++)
            chk($sformatf("R9 fifo order %0d", i), m1.log_q[ww_b + i], 32'h0000_0400 + 32'(4*i));

        // R10: read right behind a buffered write to the same block
        access(1'b1, 1'b1, 32'h0000_0500, 32'hCCCC_0005, q, st);
        access(1'b1, 1'b0, 32'h0000_0500, 32'h0, q, st);
        chk("R10 read sees drained write", q, 32'hCCCC_0005);
        chk("R10 no block writes in write-through", m1.n_bw, 0);
        chk("R11 handshake held wb", m0.viol, 0);
        chk("R11 handshake held wt", m1.viol, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(10 * 150000);
        checks++;
        errors++;
        $display("FAIL R11 watchdog expired actual hang expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule